// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM

This block is a synchronous static RAM with a flow-through, no-turnaround interface and a small internal array. On each rising clock edge it decodes three chip selects, a write strobe, a load/advance control, a stall input and per-lane write strobes. A selected cycle either loads a new address and opens a read or write burst, or continues the running operation at the next burst address. Read data flows from the array to the shared data bus in the same cycle that follows the edge, with no output register.

The bus is bidirectional. It is driven only during read cycles while the asynchronous output enable is low, and it is tri-stated in every other case. A sleep request, sampled through two flops, parks the block with its contents intact. Commands are then refused until a short recovery window has passed after the request drops. The burst order is picked by a mode input, either linear (wrapping add) or interleaved (XOR).

Top module: `flowThroughSram`

## Requirements
- R1: An edge with `advance`=0 and `stall`=0 deselects the block when `selAN`=1, `selB`=0 or `selCN`=1. In the following cycle `dq` is tri-stated.
- R2: An edge with `advance`=1 that follows a deselect keeps the block deselected, whatever the chip selects and `writeN` are. `dq` stays tri-stated.
- R3: A selected edge with `advance`=0 and `writeN`=1 starts a read at `addr`. Right after that edge, with `outEnN`=0, `dq` carries the stored word at that address, and no further clock edge is needed.
- R4: Each edge with `advance`=1 during a burst moves to the next address. Only the low two address bits change. With `burstLinear`=1 the k-th beat uses (start+k) mod 4, and with `burstLinear`=0 it uses start XOR k. The sequence wraps after four beats.
- R5: A selected edge with `advance`=0 and `writeN`=0 starts a write burst. The word on `dq` and the strobes on `laneWrN` are captured at the edge that ends each write cycle. Continue edges write the following burst addresses and ignore the chip selects and `writeN`.
- R6: Lane i (bits 8i+7:8i) is stored only when `laneWrN[i]`=0. Lanes whose strobe is high keep their old contents.
- R7: `dq` is never driven during a write cycle, even when `outEnN`=0.
- R8: During a read cycle `outEnN` gates `dq` without waiting for a clock edge. `dq` is tri-stated while `outEnN`=1 and shows the data while `outEnN`=0.
- R9: An edge with `stall`=1 changes neither the address nor the operation and writes nothing, so read data is held.
- R10: While `rstN` is low, and after reset until a read starts, the block is deselected and `dq` is tri-stated, even with `outEnN`=0.
- R11: A rising `sleepReq` is seen through two flops. Commands at the first two edges after it rises are still accepted. From the second edge onwards the bus is tri-stated, any pending access is dropped without writing, and array contents are kept.
- R12: After `sleepReq` falls, commands at the next four edges are ignored and treated as deselects. The fifth edge accepts commands again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| selAN | input | 1 | Chip select A, active low |
| selB | input | 1 | Chip select B, active high |
| selCN | input | 1 | Chip select C, active low |
| writeN | input | 1 | Write strobe, low selects write on a load edge |
| advance | input | 1 | 1 continues the burst, 0 loads a new command |
| stall | input | 1 | 1 inserts a wait state on this edge |
| laneWrN | input | 4 | Per-lane write strobes, active low |
| outEnN | input | 1 | Asynchronous output enable, active low |
| burstLinear | input | 1 | 1 linear burst order, 0 interleaved |
| sleepReq | input | 1 | Asynchronous sleep request, active high |
| addr | input | 6 | Word address loaded on a command edge |
| dq | inout | 32 | Bidirectional data bus |

## Verification
Bursts are run in both orders from several start offsets. An interleaved read from an odd start is the pattern that tells XOR from add, and a five-beat linear read shows whether the sequence wraps. Write bursts with different lane masks over a known word tell a full write from a partial one. A stalled write followed by a good data cycle, with a guard word next to it, shows whether a wait state moves the address. The sleep sequence places a read just before entry, a write at the entry edge and reads on each edge of recovery. This tells a correct two-flop entry and four-edge exit from windows that are one edge off, and it shows that the pending write was dropped.

// File: rtl/ftSramPkg.sv
package ftSramPkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } ftOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic commitWrite;  // store the bus word at this edge
    logic readCycle;    // current cycle is a read beat
    logic sleeping;     // synchronised sleep flag
  } ftStrobe_t;

endpackage

// File: rtl/ftSramCtrl.sv
module ftSramCtrl
  import ftSramPkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BURST_LEN = 4,
  parameter int RECOV_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selAN,
  input  logic              selB,
  input  logic              selCN,
  input  logic              writeN,
  input  logic              advance,
  input  logic              stall,
  input  logic              burstLinear,
  input  logic              sleepReq,
  input  logic [ADDR_W-1:0] addrIn,
  output ftStrobe_t         stb,
  output logic              cmdReady,
  output logic [ADDR_W-1:0] accessAddr
);

  localparam int CNT_W   = $clog2(BURST_LEN);
  localparam int RECOV_W = $clog2(RECOV_CYC + 1);

  ftOp_e             opReg;
  logic [ADDR_W-1:0] baseAddr;
  logic [CNT_W-1:0]  beatCnt;
  logic              sleepSync;
  logic              sleepFlag;
  logic [RECOV_W-1:0] recovCnt;
  logic              deselect;
  logic [CNT_W-1:0]  lowBits;

  assign deselect = selAN | ~selB | selCN;
  assign cmdReady = ~sleepFlag && (recovCnt == '0);

  // two-flop sampling of the asynchronous sleep request, then recovery
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepSync <= 1'b0;
      sleepFlag <= 1'b0;
      recovCnt  <= '0;
    end else begin
      sleepSync <= sleepReq;
      sleepFlag <= sleepSync;
      if (sleepFlag)
        recovCnt <= RECOV_W'(RECOV_CYC);
      else if (recovCnt != '0)
        recovCnt <= recovCnt - 1'b1;
    end
  end

  // command decode and burst state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg    <= OP_IDLE;
      baseAddr <= '0;
      beatCnt  <= '0;
    end else if (!cmdReady) begin
      opReg <= OP_IDLE;
    end else if (!stall) begin
      if (!advance) begin
        if (deselect) begin
          opReg <= OP_IDLE;
        end else begin
          opReg    <= writeN ? OP_READ : OP_WRITE;
          baseAddr <= addrIn;
          beatCnt  <= '0;
        end
      end else if (opReg != OP_IDLE) begin
        beatCnt <= beatCnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (burstLinear)
      lowBits = baseAddr[CNT_W-1:0] + beatCnt;
    else
      lowBits = baseAddr[CNT_W-1:0] ^ beatCnt;
  end

  assign accessAddr      = {baseAddr[ADDR_W-1:CNT_W], lowBits};
  assign stb.readCycle   = (opReg == OP_READ);
  assign stb.commitWrite = cmdReady && !stall && (opReg == OP_WRITE);
  assign stb.sleeping    = sleepFlag;

endmodule

// File: rtl/ftSramData.sv
module ftSramData
  import ftSramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  ftStrobe_t               stb,
  input  logic [ADDR_W-1:0]       accessAddr,
  input  logic [LANES-1:0]        laneWrN,
  input  logic                    outEnN,
  input  logic [LANES*LANE_W-1:0] busIn,
  output logic [LANES*LANE_W-1:0] rdWord,
  output logic                    dqOe
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH][LANES];

  always_ff @(posedge clk) begin
    if (stb.commitWrite) begin
      for (int i = 0; i < LANES; i++) begin
        if (!laneWrN[i])
          mem[accessAddr][i] <= busIn[i*LANE_W +: LANE_W];
      end
    end
  end

  // flow-through read path, one slice per lane
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign rdWord[g*LANE_W +: LANE_W] = mem[accessAddr][g];
  end

  // output enable acts without the clock
  assign dqOe = stb.readCycle && !outEnN && !stb.sleeping;

endmodule

// File: rtl/flowThroughSram.sv
module flowThroughSram
  import ftSramPkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int LANES     = 4,
  parameter int LANE_W    = 8,
  parameter int BURST_LEN = 4,
  parameter int RECOV_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    selAN,
  input  logic                    selB,
  input  logic                    selCN,
  input  logic                    writeN,
  input  logic                    advance,
  input  logic                    stall,
  input  logic [LANES-1:0]        laneWrN,
  input  logic                    outEnN,
  input  logic                    burstLinear,
  input  logic                    sleepReq,
  input  logic [ADDR_W-1:0]       addr,
  inout  wire  [LANES*LANE_W-1:0] dq
);

  localparam int DATA_W = LANES * LANE_W;

  ftStrobe_t         stb;
  logic              cmdReady;
  logic [ADDR_W-1:0] accessAddr;
  logic [DATA_W-1:0] rdWord;
  logic              dqOe;

  ftSramCtrl #(
    .ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN), .RECOV_CYC(RECOV_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .selAN(selAN), .selB(selB), .selCN(selCN),
    .writeN(writeN), .advance(advance), .stall(stall),
    .burstLinear(burstLinear), .sleepReq(sleepReq), .addrIn(addr),
    .stb(stb), .cmdReady(cmdReady), .accessAddr(accessAddr)
  );

  ftSramData #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
  ) uData (
    .clk(clk), .stb(stb), .accessAddr(accessAddr), .laneWrN(laneWrN),
    .outEnN(outEnN), .busIn(dq), .rdWord(rdWord), .dqOe(dqOe)
  );

  assign dq = dqOe ? rdWord : {DATA_W{1'bz}};

endmodule

// File: rtl/flowThroughSram_chk.sv
module flowThroughSram_chk
  import ftSramPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              selAN,
  input logic              selB,
  input logic              selCN,
  input logic              writeN,
  input logic              advance,
  input logic              stall,
  input logic              outEnN,
  input ftStrobe_t         stb,
  input logic              cmdReady,
  input logic              dqOe,
  input logic [ADDR_W-1:0] accessAddr
);

  logic offSel;
  assign offSel = selAN || !selB || selCN;

  assert_deselect_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReady && !stall && !advance && offSel) |=> !dqOe);

  assert_no_read_on_continue_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.readCycle && advance) |=> !stb.readCycle);

  assert_write_hiz_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReady && !stall && !advance && !offSel && !writeN) |=> !dqOe);

  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dqOe);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(accessAddr));

  assert_stall_nowrite_R9: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !stb.commitWrite);

  assert_sleep_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    stb.sleeping |-> (!dqOe && !stb.commitWrite));

  assert_recovery_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stb.sleeping) |-> !cmdReady);

  always_comb begin
    if (!rstN) begin
      assert_reset_hiz_R10: assert (!dqOe);
    end
  end

endmodule

bind flowThroughSram flowThroughSram_chk #(.ADDR_W(ADDR_W)) chk (.*);

// File: tb/flowThroughSram_test.sv
`timescale 1ns/1ps
module flowThroughSram_test;

  localparam logic [31:0] HIZ = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selAN = 1'b1, selB = 1'b0, selCN = 1'b1;
  logic writeN = 1'b1, advance = 1'b0, stall = 1'b0;
  logic [3:0] laneWrN = 4'hF;
  logic outEnN = 1'b0, burstLinear = 1'b1, sleepReq = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] tbDq = '0;
  logic tbDrive = 1'b0;
  wire  [31:0] dq;

  logic [31:0] model [64];
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  assign dq = tbDrive ? tbDq : 32'hzzzz_zzzz;
  for (genvar i = 0; i < 32; i++) begin : gPull
    pullup pu (dq[i]);
  end

  flowThroughSram uut (
    .clk(clk), .rstN(rstN), .selAN(selAN), .selB(selB), .selCN(selCN),
    .writeN(writeN), .advance(advance), .stall(stall), .laneWrN(laneWrN),
    .outEnN(outEnN), .burstLinear(burstLinear), .sleepReq(sleepReq),
    .addr(addr), .dq(dq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [5:0] beatAddr(input logic [5:0] b, input int k, input logic lin);
    logic [1:0] kk;
    kk = 2'(k);
    return {b[5:2], lin ? (b[1:0] + kk) : (b[1:0] ^ kk)};
  endfunction

  task automatic cmdIdle();
    advance = 0; selAN = 1; selB = 0; selCN = 1; writeN = 1; stall = 0;
  endtask

  task automatic cmdRead(input logic [5:0] a);
    advance = 0; selAN = 0; selB = 1; selCN = 0; writeN = 1; addr = a; stall = 0;
  endtask

  task automatic cmdWrite(input logic [5:0] a);
    advance = 0; selAN = 0; selB = 1; selCN = 0; writeN = 0; addr = a; stall = 0;
  endtask

  task automatic cmdCont();
    advance = 1; selAN = 1; selB = 0; writeN = ~writeN; stall = 0;
  endtask

  task automatic storeModel(input logic [5:0] a, input logic [31:0] d, input logic [3:0] m);
    for (int i = 0; i < 4; i++)
      if (!m[i]) model[a][i*8 +: 8] = d[i*8 +: 8];
  endtask

  task automatic writeBurst(input logic [5:0] base, input logic lin, input int n,
                            input logic [31:0] seed, input logic [3:0] mask);
    burstLinear = lin;
    cmdWrite(base);
    tick();
    for (int k = 0; k < n; k++) begin
      check("R7 bus idle in write cycle", dq, HIZ);
      tbDq = seed + 32'(k) * 32'h0101_0101;
      tbDrive = 1; laneWrN = mask;
      if (k < n - 1) cmdCont(); else cmdIdle();
      tick();
      storeModel(beatAddr(base, k, lin), tbDq, mask);
      tbDrive = 0; laneWrN = 4'hF;
      #1;
    end
  endtask

  task automatic readBurst(input logic [5:0] base, input logic lin, input int n, input string req);
    burstLinear = lin;
    cmdRead(base);
    tick();
    for (int k = 0; k < n; k++) begin
      check(req, dq, model[beatAddr(base, k, lin)]);
      if (k < n - 1) cmdCont(); else cmdIdle();
      tick();
    end
  endtask

  task automatic tReset();
    rstN = 0; outEnN = 0;
    cmdRead(6'd3);
    tick(); tick();
    check("R10 reset tri-state", dq, HIZ);
    cmdIdle();
    rstN = 1;
    tick();
    check("R10 idle after reset", dq, HIZ);
  endtask

  task automatic tBursts();
    writeBurst(6'd8, 1'b1, 4, 32'h1020_3040, 4'h0);
    writeBurst(6'd14, 1'b0, 4, 32'h5060_7080, 4'h0);
    readBurst(6'd10, 1'b1, 4, "R3 R4 linear read from offset 2");
    readBurst(6'd9, 1'b0, 4, "R4 interleaved read from offset 1");
    readBurst(6'd8, 1'b1, 5, "R4 linear wrap after four beats");
    readBurst(6'd12, 1'b1, 4, "R5 interleaved write burst placement");
    check("R1 idle after burst", dq, HIZ);
  endtask

  task automatic tLanes();
    writeBurst(6'd20, 1'b1, 1, 32'h1122_3344, 4'h0);
    writeBurst(6'd20, 1'b1, 1, 32'hAABB_CCDD, 4'b1010);
    check("R6 lane model", model[20], 32'h11BB_33DD);
    readBurst(6'd20, 1'b1, 1, "R6 partial lane write");
  endtask

  task automatic tDeselect();
    for (int v = 0; v < 3; v++) begin
      cmdRead(6'd8);
      if (v == 0) selAN = 1;
      if (v == 1) selB = 0;
      if (v == 2) selCN = 1;
      tick();
      check("R1 deselect variant", dq, HIZ);
      advance = 1; selAN = 0; selB = 1; selCN = 0; writeN = 1;
      tick();
      check("R2 continue deselect", dq, HIZ);
    end
    cmdIdle();
    tick();
  endtask

  task automatic tOutEnable();
    cmdRead(6'd9);
    burstLinear = 1;
    tick();
    check("R8 data with enable", dq, model[9]);
    outEnN = 1; #1;
    check("R8 tri-state without edge", dq, HIZ);
    outEnN = 0; #1;
    check("R8 data again without edge", dq, model[9]);
    cmdIdle();
    tick();
  endtask

  task automatic tStall();
    burstLinear = 1;
    cmdRead(6'd8);
    tick();
    check("R9 first beat", dq, model[8]);
    cmdCont(); stall = 1;
    tick();
    check("R9 held during wait", dq, model[8]);
    tick();
    check("R9 held second wait", dq, model[8]);
    stall = 0;
    tick();
    check("R9 advance after wait", dq, model[9]);
    cmdIdle();
    tick();
    writeBurst(6'd30, 1'b1, 1, 32'h3030_3030, 4'h0);
    writeBurst(6'd31, 1'b1, 1, 32'h3131_3131, 4'h0);
    cmdWrite(6'd30);
    tick();
    tbDq = 32'hDEAD_0001; tbDrive = 1; laneWrN = 4'h0; stall = 1; advance = 1;
    tick();
    tbDq = 32'h600D_0002; stall = 0; cmdIdle();
    tick();
    tbDrive = 0; laneWrN = 4'hF;
    model[30] = 32'h600D_0002;
    #1;
    readBurst(6'd30, 1'b1, 2, "R9 stalled write kept address");
  endtask

  task automatic tSleep();
    writeBurst(6'd40, 1'b1, 1, 32'h4040_4040, 4'h0);
    writeBurst(6'd44, 1'b1, 1, 32'h4444_4444, 4'h0);
    burstLinear = 1;
    sleepReq = 1;
    cmdRead(6'd40);
    tick();
    check("R11 first edge still awake", dq, model[40]);
    cmdWrite(6'd44);
    tick();
    check("R11 asleep after second edge", dq, HIZ);
    tbDq = 32'hBAD0_BAD0; tbDrive = 1; laneWrN = 4'h0;
    cmdRead(6'd40);
    tick();
    tbDrive = 0; laneWrN = 4'hF;
    #1;
    check("R11 asleep refuses read", dq, HIZ);
    tick();
    check("R11 still asleep", dq, HIZ);
    sleepReq = 0;
    for (int i = 0; i < 4; i++) begin
      cmdRead(6'd40);
      tick();
      check("R12 recovery ignores command", dq, HIZ);
    end
    cmdRead(6'd40);
    tick();
    check("R12 R11 first accepted read keeps contents", dq, model[40]);
    cmdIdle();
    tick();
    readBurst(6'd44, 1'b1, 1, "R11 pending write dropped");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tReset();
    tBursts();
    tLanes();
    tDeselect();
    tOutEnable();
    tStall();
    tSleep();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule